// File: doc/BRIEF.md
# Write Ordering Queue for a Bus Bridge

This block sits between the initiator side and the target side of a bus bridge and sorts incoming write commands by class. Memory writes (plain and invalidating) are posted. They are accepted at once into a FIFO and later drained to the target side in arrival order. I/O and configuration writes are delayed. The first attempt is answered with retry and stored in a small table of slots. The entry is then sent to the target side and waits there for a completion. When the requester repeats the identical write (same command, address and data), the block answers with the stored completion and releases the slot.

A delayed write is never sent to the target side while a posted write that was accepted before it is still waiting in the FIFO. Posted writes may overtake delayed writes. The initiator-side answer is combinational on the request inputs. The target side uses a valid/ready transfer, and a separate completion strobe ends the one delayed write that is outstanding.

Top module: `dtq_order_queue`

## Requirements
- R1: Command 4'b0111 or 4'b1111 with `req_valid` is answered with `rsp_code` 1 (accept) in the same cycle when the posted FIFO holds fewer than POST_DEPTH entries. The write is stored.
- R2: A posted command that arrives while the FIFO holds POST_DEPTH entries is answered with `rsp_code` 2 (retry) and is not stored.
- R3: Command 4'b0011 or 4'b1011 that matches no occupied slot is answered with retry. It is written into the lowest-numbered free slot if one exists.
- R4: When every slot is occupied, a non-matching delayed command is answered with retry, is not stored and never appears on the target side.
- R5: A delayed write is not presented on `tgt_*` while any posted write accepted before it has not yet been transferred.
- R6: Posted writes appear on the target side in acceptance order, with command, address and data unchanged. A write leaves the FIFO when `tgt_valid` and `tgt_ready` are both high.
- R7: At most one delayed write is outstanding, from its transfer until `cpl_valid`. A `cpl_valid` while none is outstanding has no effect.
- R8: A delayed command matching a completed slot on command, address and data is answered with `rsp_code` 3 (done). `rsp_err` carries the stored `cpl_err` value, and the slot is freed. An identical later request is therefore treated as new.
- R9: A delayed command matching a slot that is not yet completed is answered with retry and creates no second entry.
- R10: Any other command is answered with `rsp_code` 0 and changes no state.
- R11: During and right after reset, `rsp_code` is 0 and `tgt_valid` is low.
- R12: When a delayed write is eligible (no older posted write pending, none outstanding), it is presented before the FIFO head. Among eligible slots, the lowest-numbered one is presented first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Initiator-side request present |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | 32 | Request address |
| req_data | input | 32 | Request write data |
| rsp_code | output | 2 | 0 none, 1 accept, 2 retry, 3 done |
| rsp_err | output | 1 | Completion error status, meaningful with done |
| tgt_valid | output | 1 | Target-side write presented |
| tgt_cmd | output | 4 | Presented command |
| tgt_addr | output | 32 | Presented address |
| tgt_data | output | 32 | Presented data |
| tgt_ready | input | 1 | Target side takes the presented write |
| cpl_valid | input | 1 | Outstanding delayed write finished |
| cpl_err | input | 1 | Error status of that completion |

## Verification
Several functions can act in the same clock edge, and each pair below is provoked on purpose. In the first pair, a delayed write is stored while a posted write leaves the FIFO, so its count of posted writes ahead must exclude the departing one. In the second, a repeated request arrives in the very cycle its completion is strobed; it must still see the old slot state and get retry. Directed phases force these coincidences. A long random phase over a tiny address space then makes them frequent. A behavioural model in the bench predicts every port value on every cycle, so an error in either outcome shows up as a mismatch on the response or on the target-side write.

// File: rtl/dtq_pkg.sv
package dtq_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CMD_W  = 4;

    localparam logic [CMD_W-1:0] CMD_IO_WR   = 4'b0011;
    localparam logic [CMD_W-1:0] CMD_MEM_WR  = 4'b0111;
    localparam logic [CMD_W-1:0] CMD_CFG_WR  = 4'b1011;
    localparam logic [CMD_W-1:0] CMD_MEM_WRI = 4'b1111;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } txn_t;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_ACCEPT = 2'd1,
        RSP_RETRY  = 2'd2,
        RSP_DONE   = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_WAIT = 2'd1,
        SLOT_BUSY = 2'd2,
        SLOT_DONE = 2'd3
    } slot_e;

    function automatic logic is_posted(input logic [CMD_W-1:0] c);
        return (c == CMD_MEM_WR) || (c == CMD_MEM_WRI);
    endfunction

    function automatic logic is_delayed(input logic [CMD_W-1:0] c);
        return (c == CMD_IO_WR) || (c == CMD_CFG_WR);
    endfunction

endpackage

// File: rtl/dtq_pick_low.sv
module dtq_pick_low #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/dtq_post_fifo.sv
module dtq_post_fifo
    import dtq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  txn_t          push_tx,
    input  logic          pop,
    output txn_t          head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);

    txn_t          mem [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;
    logic [CW-1:0] cnt;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);
    assign level = cnt;
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
            for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_tx;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/dtq_dly_table.sv
module dtq_dly_table
    import dtq_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int PDEPTH = 4,
    parameter int IW     = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    parameter int BW     = $clog2(PDEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_dly,
    input  txn_t          req_tx,
    input  logic [BW-1:0] post_level,
    input  logic          post_pop,
    input  logic          dly_fire,
    input  logic          cpl_valid,
    input  logic          cpl_err,
    output logic          hit_done,
    output logic          hit_err,
    output logic          elig_valid,
    output txn_t          elig_tx,
    output logic          dly_busy
);

    slot_e         st  [SLOTS];
    txn_t          tx  [SLOTS];
    logic [BW-1:0] bar [SLOTS];
    logic          err [SLOTS];
    logic          busy_q;
    logic [IW-1:0] busy_idx;

    logic [SLOTS-1:0] match_v, free_v, elig_v;
    logic             hit_found, free_found, elig_found;
    logic [IW-1:0]    hit_idx, free_idx, elig_idx;
    logic             enq, rel;
    logic [BW-1:0]    bar_init;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign match_v[g] = (st[g] != SLOT_FREE) && (tx[g] == req_tx);
        assign free_v[g]  = (st[g] == SLOT_FREE);
        assign elig_v[g]  = (st[g] == SLOT_WAIT) && (bar[g] == '0);
    end

    dtq_pick_low #(.N(SLOTS), .IW(IW)) u_hit  (.vec(match_v), .found(hit_found),  .idx(hit_idx));
    dtq_pick_low #(.N(SLOTS), .IW(IW)) u_free (.vec(free_v),  .found(free_found), .idx(free_idx));
    dtq_pick_low #(.N(SLOTS), .IW(IW)) u_elig (.vec(elig_v),  .found(elig_found), .idx(elig_idx));

    assign hit_done   = hit_found && (st[hit_idx] == SLOT_DONE);
    assign hit_err    = err[hit_idx];
    assign elig_valid = elig_found && !busy_q;
    assign elig_tx    = tx[elig_idx];
    assign dly_busy   = busy_q;

    assign enq      = req_dly && !hit_found && free_found;
    assign rel      = req_dly && hit_done;
    assign bar_init = post_level - BW'(post_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SLOTS; k++) begin
                st[k]  <= SLOT_FREE;
                tx[k]  <= '0;
                bar[k] <= '0;
                err[k] <= 1'b0;
            end
            busy_q   <= 1'b0;
            busy_idx <= '0;
        end else begin
            if (post_pop) begin
                for (int k = 0; k < SLOTS; k++) begin
                    if (st[k] == SLOT_WAIT && bar[k] != '0) bar[k] <= bar[k] - 1'b1;
                end
            end
            if (dly_fire) begin
                st[elig_idx] <= SLOT_BUSY;
                busy_q       <= 1'b1;
                busy_idx     <= elig_idx;
            end
            if (cpl_valid && busy_q) begin
                st[busy_idx]  <= SLOT_DONE;
                err[busy_idx] <= cpl_err;
                busy_q        <= 1'b0;
            end
            if (rel) st[hit_idx] <= SLOT_FREE;
            if (enq) begin
                st[free_idx]  <= SLOT_WAIT;
                tx[free_idx]  <= req_tx;
                bar[free_idx] <= bar_init;
            end
        end
    end

endmodule

// File: rtl/dtq_order_queue.sv
module dtq_order_queue
    import dtq_pkg::*;
#(
    parameter int POST_DEPTH = 4,
    parameter int DLY_SLOTS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic [1:0]        rsp_code,
    output logic              rsp_err,
    output logic              tgt_valid,
    output logic [CMD_W-1:0]  tgt_cmd,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [DATA_W-1:0] tgt_data,
    input  logic              tgt_ready,
    input  logic              cpl_valid,
    input  logic              cpl_err
);

    localparam int LW = $clog2(POST_DEPTH + 1);

    txn_t          req_tx, post_head, elig_tx, out_tx;
    logic          req_post, req_dly;
    logic          post_full, post_empty, post_push, post_pop;
    logic [LW-1:0] post_level;
    logic          hit_done, hit_err, elig_valid, dly_busy;
    logic          sel_dly, fire, dly_fire;
    rsp_e          rsp;

    assign req_tx   = '{cmd: req_cmd, addr: req_addr, data: req_data};
    assign req_post = req_valid && is_posted(req_cmd);
    assign req_dly  = req_valid && is_delayed(req_cmd);

    always_comb begin
        rsp = RSP_NONE;
        if (req_post)     rsp = post_full ? RSP_RETRY : RSP_ACCEPT;
        else if (req_dly) rsp = hit_done ? RSP_DONE : RSP_RETRY;
    end

    assign rsp_code  = rsp;
    assign rsp_err   = req_dly && hit_done && hit_err;
    assign post_push = req_post && !post_full;

    assign sel_dly   = elig_valid;
    assign tgt_valid = sel_dly || !post_empty;
    assign out_tx    = sel_dly ? elig_tx : post_head;
    assign tgt_cmd   = out_tx.cmd;
    assign tgt_addr  = out_tx.addr;
    assign tgt_data  = out_tx.data;
    assign fire      = tgt_valid && tgt_ready;
    assign dly_fire  = fire && sel_dly;
    assign post_pop  = fire && !sel_dly;

    dtq_post_fifo #(.DEPTH(POST_DEPTH)) u_post (
        .clk     (clk),
        .rst     (rst),
        .push    (post_push),
        .push_tx (req_tx),
        .pop     (post_pop),
        .head    (post_head),
        .level   (post_level),
        .full    (post_full),
        .empty   (post_empty)
    );

    dtq_dly_table #(.SLOTS(DLY_SLOTS), .PDEPTH(POST_DEPTH)) u_dly (
        .clk        (clk),
        .rst        (rst),
        .req_dly    (req_dly),
        .req_tx     (req_tx),
        .post_level (post_level),
        .post_pop   (post_pop),
        .dly_fire   (dly_fire),
        .cpl_valid  (cpl_valid),
        .cpl_err    (cpl_err),
        .hit_done   (hit_done),
        .hit_err    (hit_err),
        .elig_valid (elig_valid),
        .elig_tx    (elig_tx),
        .dly_busy   (dly_busy)
    );

endmodule

// File: rtl/dtq_order_queue_chk.sv
module dtq_order_queue_chk
    import dtq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [CMD_W-1:0] req_cmd,
    input logic [1:0]       rsp_code,
    input logic             rsp_err,
    input logic             tgt_valid,
    input logic             tgt_ready,
    input logic [CMD_W-1:0] tgt_cmd,
    input logic             cpl_valid,
    input logic             post_full
);

    logic dly_out;

    always_ff @(posedge clk) begin
        if (rst) dly_out <= 1'b0;
        else if (tgt_valid && tgt_ready && is_delayed(tgt_cmd)) dly_out <= 1'b1;
        else if (cpl_valid) dly_out <= 1'b0;
    end

    // R10
    other_cmd_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !is_posted(req_cmd) && !is_delayed(req_cmd)) |-> (rsp_code == 2'd0));

    // R2
    posted_full_retry_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_posted(req_cmd) && post_full) |-> (rsp_code == 2'd2));

    // R3
    delayed_never_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_delayed(req_cmd)) |-> (rsp_code == 2'd2 || rsp_code == 2'd3));

    // R8
    err_only_done_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_code == 2'd3));

    // R7
    single_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_valid && is_delayed(tgt_cmd)) |-> !dly_out);

endmodule

bind dtq_order_queue dtq_order_queue_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_cmd   (req_cmd),
    .rsp_code  (rsp_code),
    .rsp_err   (rsp_err),
    .tgt_valid (tgt_valid),
    .tgt_ready (tgt_ready),
    .tgt_cmd   (tgt_cmd),
    .cpl_valid (cpl_valid),
    .post_full (post_full)
);

// File: tb/test_dtq_order_queue.sv
module test_dtq_order_queue;

    localparam int CLK_PERIOD = 10;
    localparam int PD = 4;
    localparam int NS = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  req_cmd = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic [1:0]  rsp_code;
    logic        rsp_err;
    logic        tgt_valid;
    logic [3:0]  tgt_cmd;
    logic [31:0] tgt_addr;
    logic [31:0] tgt_data;
    logic        tgt_ready = 1'b0;
    logic        cpl_valid = 1'b0;
    logic        cpl_err = 1'b0;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string tag = "R11";

    always #(CLK_PERIOD / 2) clk = ~clk;

    dtq_order_queue #(.POST_DEPTH(PD), .DLY_SLOTS(NS)) i_dtq_order_queue (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_addr(req_addr), .req_data(req_data),
        .rsp_code(rsp_code), .rsp_err(rsp_err),
        .tgt_valid(tgt_valid), .tgt_cmd(tgt_cmd), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
        .tgt_ready(tgt_ready), .cpl_valid(cpl_valid), .cpl_err(cpl_err)
    );

    // reference model: posted queue and delayed slots (0 free, 1 waiting, 2 out, 3 completed)
    logic [67:0] pq[$];
    int          st  [NS];
    logic [67:0] sx  [NS];
    int          bar [NS];
    bit          serr[NS];
    bit          infl;
    int          iidx;

    task automatic check(input string what, input logic [67:0] act, input logic [67:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            pq.delete();
            for (int k = 0; k < NS; k++) begin st[k] = 0; bar[k] = 0; serr[k] = 0; sx[k] = '0; end
            infl = 0; iidx = 0;
            check("reset rsp", 68'(rsp_code), 68'd0);
            check("reset tgt_valid", 68'(tgt_valid), 68'd0);
        end else begin
            logic [67:0] rtx, etx;
            bit posted, dly, etv, pop;
            int hit, fre, elig, ersp, eerr;
            rtx    = {req_cmd, req_addr, req_data};
            posted = req_valid && (req_cmd == 4'd7 || req_cmd == 4'd15);
            dly    = req_valid && (req_cmd == 4'd3 || req_cmd == 4'd11);
            hit = -1; fre = -1; elig = -1;
            for (int k = NS - 1; k >= 0; k--) begin
                if (st[k] != 0 && sx[k] == rtx) hit = k;
                if (st[k] == 0) fre = k;
                if (!infl && st[k] == 1 && bar[k] == 0) elig = k;
            end
            ersp = posted ? ((pq.size() == PD) ? 2 : 1) :
                   dly    ? ((hit >= 0 && st[hit] == 3) ? 3 : 2) : 0;
            eerr = (ersp == 3) ? int'(serr[hit]) : 0;
            etv  = (elig >= 0) || (pq.size() > 0);
            etx  = (elig >= 0) ? sx[elig] : ((pq.size() > 0) ? pq[0] : '0);
            check("rsp_code", 68'(rsp_code), 68'(ersp));
            check("rsp_err", 68'(rsp_err), 68'(eerr));
            check("tgt_valid", 68'(tgt_valid), 68'(etv));
            if (etv) check("tgt txn", {tgt_cmd, tgt_addr, tgt_data}, etx);
            // state update for the coming edge
            pop = 0;
            if (etv && tgt_ready) begin
                if (elig >= 0) begin st[elig] = 2; infl = 1; iidx = elig; end
                else pop = 1;
            end
            if (cpl_valid && infl && !(etv && tgt_ready && elig >= 0)) begin
                st[iidx] = 3; serr[iidx] = cpl_err; infl = 0;
            end
            if (pop) begin
                void'(pq.pop_front());
                for (int k = 0; k < NS; k++) if (st[k] == 1 && bar[k] > 0) bar[k]--;
            end
            if (posted && ersp == 1) pq.push_back(rtx);
            if (dly) begin
                if (hit >= 0 && ersp == 3) st[hit] = 0;
                else if (hit < 0 && fre >= 0) begin
                    st[fre] = 1; sx[fre] = rtx; serr[fre] = 0;
                    bar[fre] = pq.size() - (posted && ersp == 1 ? 1 : 0);
                end
            end
        end
    end

    task automatic drive(input bit v, input logic [3:0] c, input logic [31:0] a,
                         input logic [31:0] d, input bit rdy, input bit cv, input bit ce);
        req_valid = v; req_cmd = c; req_addr = a; req_data = d;
        tgt_ready = rdy; cpl_valid = cv; cpl_err = ce;
        @(posedge clk); #1;
    endtask

    task automatic idle(input int n, input bit rdy);
        for (int i = 0; i < n; i++) drive(0, 4'd0, '0, '0, rdy, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        // R11: reset state
        tag = "R11";
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        idle(2, 0);

        // R1, R2: fill the posted FIFO with target stalled, then overflow
        tag = "R2";
        for (int i = 0; i < 5; i++) drive(1, 4'd7, 32'h100 + i, 32'hA0 + i, 0, 0, 0);
        drive(1, 4'd15, 32'h200, 32'hB0, 0, 0, 0);
        // R6: drain in order
        tag = "R6";
        idle(6, 1);

        // R3, R9, R5: delayed write behind two posted writes
        tag = "R5";
        drive(1, 4'd7, 32'h300, 32'h1, 0, 0, 0);
        drive(1, 4'd15, 32'h304, 32'h2, 0, 0, 0);
        tag = "R3";
        drive(1, 4'd3, 32'h3C8, 32'h55, 0, 0, 0);
        tag = "R9";
        drive(1, 4'd3, 32'h3C8, 32'h55, 0, 0, 0);
        tag = "R5";
        idle(4, 1);
        // repeat arrives in the same cycle as its completion: still retry (R9)
        tag = "R9";
        drive(1, 4'd3, 32'h3C8, 32'h55, 0, 1, 1);
        // R8: completed with error, then released
        tag = "R8";
        drive(1, 4'd3, 32'h3C8, 32'h55, 0, 0, 0);
        drive(1, 4'd3, 32'h3C8, 32'h55, 1, 0, 0);
        idle(2, 1);
        drive(0, 4'd0, '0, '0, 1, 1, 0);
        drive(1, 4'd3, 32'h3C8, 32'h55, 1, 0, 0);

        // R4: fill all slots with target stalled, one more is dropped
        tag = "R4";
        for (int i = 0; i < NS + 1; i++) drive(1, 4'd11, 32'h40 + i, 32'h7, 0, 0, 0);
        for (int i = 0; i < NS + 1; i++) begin
            drive(0, 4'd0, '0, '0, 1, 0, 0);
            drive(0, 4'd0, '0, '0, 0, 1, i[0]);
        end
        tag = "R8";
        for (int i = 0; i < NS + 1; i++) drive(1, 4'd11, 32'h40 + i, 32'h7, 0, 0, 0);
        idle(2, 1);
        drive(0, 4'd0, '0, '0, 0, 1, 0);
        drive(1, 4'd11, 32'h40 + NS, 32'h7, 0, 0, 0);

        // R12: eligible delayed preferred over a newer posted write, in a simultaneous enqueue+pop
        tag = "R12";
        drive(1, 4'd7, 32'h500, 32'h9, 0, 0, 0);
        drive(1, 4'd3, 32'h3C6, 32'h1, 1, 0, 0);
        drive(1, 4'd7, 32'h504, 32'h9, 0, 0, 0);
        idle(3, 1);
        drive(0, 4'd0, '0, '0, 0, 1, 0);
        drive(1, 4'd3, 32'h3C6, 32'h1, 1, 0, 0);

        // R10, R7: other commands and stray completions change nothing
        tag = "R10";
        drive(1, 4'd6, 32'h10, 32'h0, 0, 0, 0);
        drive(1, 4'd2, 32'h3C9, 32'h0, 0, 0, 0);
        tag = "R7";
        drive(0, 4'd0, '0, '0, 0, 1, 1);
        drive(1, 4'd11, 32'h80, 32'h3, 1, 0, 0);
        drive(1, 4'd11, 32'h84, 32'h3, 1, 0, 0);
        idle(3, 1);

        // R12 mixed: random traffic over a tiny address space
        tag = "R12";
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] c;
            int r;
            r = $urandom_range(0, 5);
            c = (r == 0) ? 4'd7 : (r == 1) ? 4'd15 : (r == 2) ? 4'd3 :
                (r == 3) ? 4'd11 : (r == 4) ? 4'd6 : 4'd2;
            drive($urandom_range(0, 1) == 1, c, 32'($urandom_range(0, 3)),
                  32'($urandom_range(0, 1)), $urandom_range(0, 9) < 6,
                  $urandom_range(0, 9) < 3, $urandom_range(0, 1) == 1);
        end
        idle(4, 1);
        finish_run();
    end

endmodule